// File: doc/BRIEF.md
# Hub Port Link Power Manager

This block manages the link power state of each downstream port of a hub and derives a target state for the hub's upstream port. Every port has its own state machine with four states. U0 is the working state. U1 is an idle state with a short wake-up time. U2 is an idle state with a long wake-up time. U3 is suspend. A port that sees no real traffic sinks from U0 to U1 and then to U2. The two idle limits decide how long this takes. Timestamp traffic is not counted as activity in any state.

When traffic, a wake request from the link partner or a return command reaches a port in U1 or U2, the port starts its way back to U0. During this exit it holds a busy flag for a number of cycles, and that number is set separately for U1 and for U2. Suspend is entered and left only by an explicit command. The upstream target is the shallowest state found across all ports. A port that is still waking up counts as U0 for this purpose.

Top module: `lpm_hub_ctrl`

## Requirements
- R1: After reset every port reports U0, every `exit_busy` bit is low and `up_target` is U0. The state code is U0=0, U1=1, U2=2, U3=3, with 2 bits per port, and port p occupies bits [2p+1:2p] of `port_state`.
- R2: When `u1_idle_limit` is not zero, a port in U0 reports U1 after exactly `u1_idle_limit` clock edges on which it sampled no non-timestamp traffic.
- R3: When `u2_idle_limit` is not zero, a port that has spent `u2_idle_limit` edges in U1 moves to U2. If `u1_idle_limit` is zero, a port moves from U0 straight to U2 after `u2_idle_limit` idle edges.
- R4: A limit of zero disables entry into its state. With both limits at zero, a port stays in U0 indefinitely.
- R5: Traffic with `act_is_ts` high neither restarts the idle count in U0 nor starts an exit from U1 or U2.
- R6: Non-timestamp traffic sampled in U0 restarts the idle count, so the next U1 entry comes `u1_idle_limit` edges after the last such traffic.
- R7: Any of the following starts an exit from U1 or U2: non-timestamp traffic, `wake_req`, or a return command (`cmd_valid` high with `cmd_u3` low). On the next cycle `exit_busy` is high and the state is unchanged. The port reports U0 with `exit_busy` low after max(lat,1) cycles of busy. Here lat is `u1_exit_lat` when exiting U1 and `u2_exit_lat` when exiting U2.
- R8: Further wake requests or traffic during an exit do not change its length.
- R9: The state is U3 on the cycle after `cmd_valid` is sampled high with `cmd_u3` high, whatever the earlier state. This command also aborts an exit that is under way.
- R10: In U3, traffic, wake requests and the idle limits have no effect. A return command starts an exit timed by `u2_exit_lat`.
- R11: `up_target` is the lowest state code across all ports, where a port with `exit_busy` high counts as U0.
- R12: A command sampled on the same edge as traffic takes priority over the traffic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| act_valid | input | NPORTS | Packet traffic seen on each port this cycle |
| act_is_ts | input | NPORTS | The packet on that port is a timestamp |
| wake_req | input | NPORTS | Link partner requests a return to U0 |
| cmd_valid | input | NPORTS | Explicit state command for that port |
| cmd_u3 | input | NPORTS | 1 = enter U3, 0 = return to U0 |
| u1_idle_limit | input | TW | Idle edges before U1 (0 = off) |
| u2_idle_limit | input | TW | Edges in U1 (or idle in U0) before U2 (0 = off) |
| u1_exit_lat | input | LW | Busy cycles when exiting U1 |
| u2_exit_lat | input | LW | Busy cycles when exiting U2 or U3 |
| port_state | output | 2*NPORTS | Current state of each port |
| exit_busy | output | NPORTS | Port is on its way back to U0 |
| up_target | output | 2 | Target state for the upstream port |

## Verification
The bench measures the exact cycle counts of entry and exit across several limit and latency sets. These include a latency of zero, which an off-by-one design would turn into a zero-cycle or a wrapped exit. Timestamp traffic is mixed into idle periods and into U1. A design that treats it as activity enters U1 late or wakes a port by mistake. Other tests cover a second wake during an exit, a suspend command in the middle of an exit, and traffic or wake in U3. A faulty design would stretch the exit, let it finish, or leave suspend on its own. The upstream target is checked while a port is waking up, where counting the port's reported state instead of U0 gives a target that is too deep.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

   typedef enum logic [1:0] {
      LS_U0 = 2'd0,
      LS_U1 = 2'd1,
      LS_U2 = 2'd2,
      LS_U3 = 2'd3
   } link_st_e;

endpackage

// File: rtl/lpm_idle_timer.sv
module lpm_idle_timer #(
   parameter int TW = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic [TW-1:0] lim_a,
   input  logic [TW-1:0] lim_b,
   output logic          hit_a,
   output logic          hit_b
);
   localparam logic [TW-1:0] CNT_MAX = {TW{1'b1}};

   logic [TW-1:0] cnt;
   logic [TW:0]   cnt_next;

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         cnt <= '0;
      end else if (cnt != CNT_MAX) begin
         cnt <= cnt + 1'b1;
      end
   end

   // the edge being evaluated is counted, so a limit of L fires on the L-th idle edge
   assign cnt_next = {1'b0, cnt} + 1'b1;
   assign hit_a    = (lim_a != '0) && (cnt_next >= {1'b0, lim_a});
   assign hit_b    = (lim_b != '0) && (cnt_next >= {1'b0, lim_b});

   a_r4_zero_limit_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (lim_a == '0) |-> !hit_a);
endmodule

// File: rtl/lpm_exit_ctr.sv
module lpm_exit_ctr #(
   parameter int LW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          abort,
   input  logic [LW-1:0] lat,
   output logic          busy,
   output logic          last
);
   logic [LW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n || abort) begin
         cnt <= '0;
      end else if (load) begin
         cnt <= (lat == '0) ? {{(LW-1){1'b0}}, 1'b1} : lat;
      end else if (cnt != '0) begin
         cnt <= cnt - 1'b1;
      end
   end

   assign busy = (cnt != '0);
   assign last = (cnt == {{(LW-1){1'b0}}, 1'b1});

   a_r7_load_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !abort) |=> busy);
endmodule

// File: rtl/lpm_port_fsm.sv
module lpm_port_fsm
   import lpm_pkg::*;
#(
   parameter int TW = 12,
   parameter int LW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          act_valid,
   input  logic          act_is_ts,
   input  logic          wake_req,
   input  logic          cmd_valid,
   input  logic          cmd_u3,
   input  logic [TW-1:0] u1_lim,
   input  logic [TW-1:0] u2_lim,
   input  logic [LW-1:0] u1_lat,
   input  logic [LW-1:0] u2_lat,
   output link_st_e      st,
   output logic          busy
);
   link_st_e      st_n;
   logic          real_act;
   logic          go_u3;
   logic          go_u0;
   logic          tmr_clr;
   logic          ex_load;
   logic          ex_abort;
   logic          ex_last;
   logic          hit1;
   logic          hit2;
   logic          u1_on;
   logic [LW-1:0] ex_lat;

   assign real_act = act_valid && !act_is_ts;
   assign go_u3    = cmd_valid && cmd_u3;
   assign go_u0    = cmd_valid && !cmd_u3;
   assign u1_on    = (u1_lim != '0);

   lpm_idle_timer #(.TW(TW)) u_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (tmr_clr),
      .lim_a (u1_lim),
      .lim_b (u2_lim),
      .hit_a (hit1),
      .hit_b (hit2)
   );

   lpm_exit_ctr #(.LW(LW)) u_exit (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (ex_load),
      .abort (ex_abort),
      .lat   (ex_lat),
      .busy  (busy),
      .last  (ex_last)
   );

   always_comb begin
      st_n     = st;
      tmr_clr  = 1'b0;
      ex_load  = 1'b0;
      ex_abort = 1'b0;
      ex_lat   = u2_lat;
      if (go_u3) begin
         st_n     = LS_U3;
         tmr_clr  = 1'b1;
         ex_abort = 1'b1;
      end else if (busy) begin
         tmr_clr = 1'b1;
         if (ex_last) begin
            st_n = LS_U0;
         end
      end else begin
         unique case (st)
            LS_U0: begin
               if (real_act || go_u0) begin
                  tmr_clr = 1'b1;
               end else if (u1_on && hit1) begin
                  st_n    = LS_U1;
                  tmr_clr = 1'b1;
               end else if (!u1_on && hit2) begin
                  st_n    = LS_U2;
                  tmr_clr = 1'b1;
               end
            end
            LS_U1: begin
               if (real_act || wake_req || go_u0) begin
                  ex_load = 1'b1;
                  ex_lat  = u1_lat;
                  tmr_clr = 1'b1;
               end else if (hit2) begin
                  st_n    = LS_U2;
                  tmr_clr = 1'b1;
               end
            end
            LS_U2: begin
               if (real_act || wake_req || go_u0) begin
                  ex_load = 1'b1;
                  tmr_clr = 1'b1;
               end
            end
            default: begin
               if (go_u0) begin
                  ex_load = 1'b1;
                  tmr_clr = 1'b1;
               end
            end
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st <= LS_U0;
      end else begin
         st <= st_n;
      end
   end

   a_r7_busy_not_in_u0: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (st != LS_U0));
   a_r7_no_instant_exit: assert property (@(posedge clk) disable iff (!rst_n)
      (st != LS_U0 && !busy && !go_u3) |=> (st != LS_U0));
   a_r9_u3_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      go_u3 |=> (st == LS_U3 && !busy));
   a_r10_u3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (st == LS_U3 && !busy && !cmd_valid) |=> (st == LS_U3 && !busy));
   a_r9_u3_only_by_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      (st != LS_U3 && !go_u3) |=> (st != LS_U3));
   a_r5_ts_no_wake: assert property (@(posedge clk) disable iff (!rst_n)
      ((st == LS_U1 || st == LS_U2) && !busy && act_is_ts && !wake_req && !cmd_valid)
      |=> !busy);
endmodule

// File: rtl/lpm_uplink_merge.sv
module lpm_uplink_merge
   import lpm_pkg::*;
#(
   parameter int NPORTS = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [2*NPORTS-1:0]     st_flat,
   input  logic [NPORTS-1:0]       busy,
   output link_st_e                up_target
);
   link_st_e chain [NPORTS+1];
   link_st_e eff   [NPORTS];

   assign chain[0] = LS_U3;

   for (genvar i = 0; i < NPORTS; i++) begin : g_min
      assign eff[i]     = busy[i] ? LS_U0 : link_st_e'(st_flat[2*i +: 2]);
      assign chain[i+1] = (eff[i] < chain[i]) ? eff[i] : chain[i];

      a_r11_not_deeper: assert property (@(posedge clk) disable iff (!rst_n)
         up_target <= link_st_e'(st_flat[2*i +: 2]));
      a_r11_exit_wakes_up: assert property (@(posedge clk) disable iff (!rst_n)
         busy[i] |-> (up_target == LS_U0));
   end

   assign up_target = chain[NPORTS];
endmodule

// File: rtl/lpm_hub_ctrl.sv
module lpm_hub_ctrl
   import lpm_pkg::*;
#(
   parameter int NPORTS = 4,
   parameter int TW     = 12,
   parameter int LW     = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NPORTS-1:0]   act_valid,
   input  logic [NPORTS-1:0]   act_is_ts,
   input  logic [NPORTS-1:0]   wake_req,
   input  logic [NPORTS-1:0]   cmd_valid,
   input  logic [NPORTS-1:0]   cmd_u3,
   input  logic [TW-1:0]       u1_idle_limit,
   input  logic [TW-1:0]       u2_idle_limit,
   input  logic [LW-1:0]       u1_exit_lat,
   input  logic [LW-1:0]       u2_exit_lat,
   output logic [2*NPORTS-1:0] port_state,
   output logic [NPORTS-1:0]   exit_busy,
   output logic [1:0]          up_target
);
   localparam int SW = 2 * NPORTS;

   if (NPORTS < 1) begin : g_bad_ports
      $error("lpm_hub_ctrl: NPORTS must be at least 1");
   end
   if (TW < 2) begin : g_bad_tw
      $error("lpm_hub_ctrl: TW must be at least 2");
   end
   if (LW < 1) begin : g_bad_lw
      $error("lpm_hub_ctrl: LW must be at least 1");
   end

   link_st_e         up_st;
   logic [SW-1:0]    st_flat;

   for (genvar p = 0; p < NPORTS; p++) begin : g_port
      link_st_e st_p;

      lpm_port_fsm #(.TW(TW), .LW(LW)) u_fsm (
         .clk       (clk),
         .rst_n     (rst_n),
         .act_valid (act_valid[p]),
         .act_is_ts (act_is_ts[p]),
         .wake_req  (wake_req[p]),
         .cmd_valid (cmd_valid[p]),
         .cmd_u3    (cmd_u3[p]),
         .u1_lim    (u1_idle_limit),
         .u2_lim    (u2_idle_limit),
         .u1_lat    (u1_exit_lat),
         .u2_lat    (u2_exit_lat),
         .st        (st_p),
         .busy      (exit_busy[p])
      );

      assign st_flat[2*p +: 2] = st_p;
   end

   lpm_uplink_merge #(.NPORTS(NPORTS)) u_merge (
      .clk       (clk),
      .rst_n     (rst_n),
      .st_flat   (st_flat),
      .busy      (exit_busy),
      .up_target (up_st)
   );

   assign port_state = st_flat;
   assign up_target  = up_st;

   a_r1_reset_idle: assert property (@(posedge clk)
      !rst_n |=> (port_state == '0 && exit_busy == '0));
endmodule

// File: tb/lpm_hub_ctrl_tb.sv
module lpm_hub_ctrl_tb;
   localparam int NP = 4;
   localparam int TW = 12;
   localparam int LW = 8;
   localparam int NV = 5;
   // {u1 limit, u2 limit, u1 exit latency, u2 exit latency}
   localparam int VEC [NV][4] = '{
      '{3, 5, 2, 6},
      '{1, 1, 1, 1},
      '{7, 2, 0, 3},
      '{10, 4, 4, 0},
      '{2, 9, 5, 12}
   };

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NP-1:0]   act_valid = '0;
   logic [NP-1:0]   act_is_ts = '0;
   logic [NP-1:0]   wake_req = '0;
   logic [NP-1:0]   cmd_valid = '0;
   logic [NP-1:0]   cmd_u3 = '0;
   logic [TW-1:0]   u1_idle_limit = '0;
   logic [TW-1:0]   u2_idle_limit = '0;
   logic [LW-1:0]   u1_exit_lat = '0;
   logic [LW-1:0]   u2_exit_lat = '0;
   logic [2*NP-1:0] port_state;
   logic [NP-1:0]   exit_busy;
   logic [1:0]      up_target;

   int checks = 0;
   int failures = 0;
   int cycles = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   lpm_hub_ctrl #(.NPORTS(NP), .TW(TW), .LW(LW)) u_dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .act_valid     (act_valid),
      .act_is_ts     (act_is_ts),
      .wake_req      (wake_req),
      .cmd_valid     (cmd_valid),
      .cmd_u3        (cmd_u3),
      .u1_idle_limit (u1_idle_limit),
      .u2_idle_limit (u2_idle_limit),
      .u1_exit_lat   (u1_exit_lat),
      .u2_exit_lat   (u2_exit_lat),
      .port_state    (port_state),
      .exit_busy     (exit_busy),
      .up_target     (up_target)
   );

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 150000 && !done) begin
         failures = failures + 1;
         $display("FAIL watchdog: actual=%0d cycles expected=<150000", cycles);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic check(string req, int act, int exp);
      checks = checks + 1;
      if (act != exp) begin
         failures = failures + 1;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int pst(int p);
      return int'(port_state[2*p +: 2]);
   endfunction

   task automatic wait_state(int p, int s, output int n);
      n = 0;
      while (pst(p) != s && n < 300) begin
         tick();
         n++;
      end
   endtask

   // counts cycles from just after the exit was requested until U0; busy must stay high
   task automatic measure_exit(int p, output int m, output int low_seen);
      m = 0;
      low_seen = 0;
      while (pst(p) != 0 && m < 300) begin
         if (!exit_busy[p]) low_seen = 1;
         tick();
         m++;
      end
   endtask

   task automatic pulse_act(int p, bit ts);
      act_valid[p] = 1'b1;
      act_is_ts[p] = ts;
      tick();
      act_valid[p] = 1'b0;
      act_is_ts[p] = 1'b0;
   endtask

   task automatic pulse_wake(int p);
      wake_req[p] = 1'b1;
      tick();
      wake_req[p] = 1'b0;
   endtask

   task automatic command(int p, bit to_u3);
      cmd_valid[p] = 1'b1;
      cmd_u3[p]    = to_u3;
      tick();
      cmd_valid[p] = 1'b0;
      cmd_u3[p]    = 1'b0;
   endtask

   initial begin
      int n;
      int m;
      int lo;
      repeat (3) tick();
      // R1 reset state
      check("R1 state", int'(port_state), 0);
      check("R1 busy", int'(exit_busy), 0);
      check("R1 up", int'(up_target), 0);
      rst_n = 1'b1;
      tick();

      // table-driven entry and exit timing on port 0
      for (int v = 0; v < NV; v++) begin
         int e1;
         int e2;
         e1 = (VEC[v][2] == 0) ? 1 : VEC[v][2];
         e2 = (VEC[v][3] == 0) ? 1 : VEC[v][3];
         u1_idle_limit = TW'(VEC[v][0]);
         u2_idle_limit = TW'(VEC[v][1]);
         u1_exit_lat   = LW'(VEC[v][2]);
         u2_exit_lat   = LW'(VEC[v][3]);
         pulse_act(0, 1'b0);
         wait_state(0, 1, n);
         check("R2 cycles to U1", n, VEC[v][0]);
         pulse_wake(0);
         check("R7 busy after wake", int'(exit_busy[0]), 1);
         check("R7 state held", pst(0), 1);
         measure_exit(0, m, lo);
         check("R7 U1 exit length", m, e1);
         check("R7 busy held", lo, 0);
         check("R7 busy clear", int'(exit_busy[0]), 0);
         wait_state(0, 1, n);
         check("R2 cycles to U1 after exit", n, VEC[v][0]);
         wait_state(0, 2, n);
         check("R3 cycles to U2", n, VEC[v][1]);
         pulse_act(0, 1'b0);
         measure_exit(0, m, lo);
         check("R7 U2 exit length", m, e2);
      end

      // R5 timestamps during idle do not restart count; R6 real traffic does
      u1_idle_limit = 12'd5;
      u2_idle_limit = 12'd0;
      u1_exit_lat   = 8'd3;
      pulse_act(0, 1'b0);
      act_valid[0] = 1'b1;
      act_is_ts[0] = 1'b1;
      wait_state(0, 1, n);
      act_valid[0] = 1'b0;
      act_is_ts[0] = 1'b0;
      check("R5 ts ignored by idle count", n, 5);
      pulse_act(0, 1'b1);
      check("R5 ts does not wake U1 busy", int'(exit_busy[0]), 0);
      check("R5 ts does not wake U1 state", pst(0), 1);
      pulse_wake(0);
      measure_exit(0, m, lo);
      repeat (3) tick();
      pulse_act(0, 1'b0);
      wait_state(0, 1, n);
      check("R6 real traffic restarts count", n, 5);

      // R4 both limits zero: stays U0
      pulse_wake(0);
      measure_exit(0, m, lo);
      u1_idle_limit = 12'd0;
      u2_idle_limit = 12'd0;
      repeat (40) tick();
      check("R4 no entry with zero limits", pst(0), 0);
      // R3 U1 disabled: straight to U2
      u2_idle_limit = 12'd4;
      pulse_act(0, 1'b0);
      wait_state(0, 2, n);
      check("R3 U0 to U2 when U1 off", n, 4);
      check("R4 U1 skipped up", int'(up_target) <= 2, 1);

      // R8 second wake during exit does not stretch it
      u2_exit_lat = 8'd6;
      pulse_wake(0);
      tick();
      pulse_wake(0);
      measure_exit(0, m, lo);
      check("R8 exit length unchanged", m + 2, 6);

      // R12 command beats traffic; R11 all suspended
      u1_idle_limit = 12'd3;
      u2_idle_limit = 12'd0;
      u2_exit_lat   = 8'd4;
      act_valid = '1;
      cmd_valid = '1;
      cmd_u3    = '1;
      tick();
      act_valid = '0;
      cmd_valid = '0;
      cmd_u3    = '0;
      check("R12 cmd over traffic", pst(2), 3);
      check("R9 all U3", int'(port_state), 8'hFF);
      check("R11 up all U3", int'(up_target), 3);
      command(1, 1'b0);
      check("R10 return cmd busy", int'(exit_busy[1]), 1);
      check("R11 exiting port counts U0", int'(up_target), 0);
      measure_exit(1, m, lo);
      check("R10 U3 exit uses u2 latency", m, 4);
      wait_state(1, 1, n);
      check("R11 up follows U1", int'(up_target), 1);
      u2_idle_limit = 12'd2;
      wait_state(1, 2, n);
      check("R11 up follows U2", int'(up_target), 2);
      command(1, 1'b1);
      check("R11 up back to U3", int'(up_target), 3);

      // R10 traffic and wake ignored in U3
      act_valid[3] = 1'b1;
      wake_req[3]  = 1'b1;
      repeat (5) tick();
      act_valid[3] = 1'b0;
      wake_req[3]  = 1'b0;
      check("R10 U3 ignores traffic", pst(3), 3);
      check("R10 U3 no busy", int'(exit_busy[3]), 0);

      // R9 suspend command aborts an exit
      u2_exit_lat = 8'd20;
      command(1, 1'b0);
      repeat (3) tick();
      check("R9 exit in progress", int'(exit_busy[1]), 1);
      command(1, 1'b1);
      check("R9 abort to U3", pst(1), 3);
      check("R9 abort clears busy", int'(exit_busy[1]), 0);
      repeat (25) tick();
      check("R9 stays U3", pst(1), 3);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule